// File: doc/BRIEF.md
# Call-Aware Register File

This block holds the architectural registers of a small 64-bit, two-operand filter engine. There are eleven 64-bit registers, numbered 0 to 10. Register 10 is the frame pointer: programs may read it but can never change it. The file has two read ports and one write port. A write can carry a full 64-bit value, or a 32-bit value that is zero-extended to 64 bits.

Each register has a valid bit, and a read of an invalid register is reported as an error. The block also models the effect of a call into a host function. When the call completes, the return value is loaded into register 0. Registers 1 to 5, which carried the arguments, become unreadable. Registers 6 to 9 keep their contents. At program start, the single context argument is loaded into register 1.

Reads are combinational. A write, a call completion or a start request takes effect at the next rising clock edge.

Top module: `callreg_file`

## Requirements
- R1: After reset, register 1 is valid and reads zero, and register 10 is valid and reads the parameter `FP_VALUE`. Registers 0 and 2 to 9 are invalid.
- R2: A 64-bit write (`wr_half`=0) to registers 0 to 9 is readable on both ports from the next cycle on. A read in the cycle of the write still returns the old value.
- R3: A write with `wr_half`=1 stores `wr_data[31:0]` in the low half of the register and zeros in bits 63:32.
- R4: A write to index 10 or higher is dropped and raises `illegal_write` in the same cycle. Register 10 keeps `FP_VALUE`.
- R5: An enabled read of an invalid register, or of an index above 10, returns zero and raises `illegal_read` in the same cycle. A disabled port returns zero and raises no error.
- R6: When `call_done` is high at an edge, register 0 takes `call_ret` and becomes valid. At the same edge, registers 1 to 5 become invalid.
- R7: Registers 6 to 9 keep their values across a call completion.
- R8: A normal write in the same cycle as `call_done` is handled by its target:
  - A write to register 0 loses to `call_ret`.
  - A write to registers 1 to 5 is dropped.
  - A write to registers 6 to 9 is stored.
- R9: When `start` is high at an edge, register 1 takes `ctx_in` and becomes valid. This overrides a write to register 1 and the invalidation done by a call completion in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Program start: load context into register 1 |
| ctx_in | input | 64 | Context argument |
| rd_a_en | input | 1 | Read port A enable |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 64 | Read port A data |
| rd_b_en | input | 1 | Read port B enable |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 64 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_half | input | 1 | 1: 32-bit zero-extending write |
| wr_idx | input | 4 | Write register index |
| wr_data | input | 64 | Write data |
| call_done | input | 1 | Host function call has returned |
| call_ret | input | 64 | Value returned by the call |
| illegal_read | output | 1 | An enabled read hit an invalid register |
| illegal_write | output | 1 | A write targeted the frame pointer or a bad index |

## Verification
The bench sends a call completion together with a write to register 0. A design that got this priority wrong would leave the written data in register 0 instead of the returned value.

It also sends a call completion together with writes to an argument register and to a callee-saved register. A design with the wrong per-class rules would either revive a dead argument register or lose the callee-saved update.

The bench writes 32-bit values whose upper data bits are set. A missing zero-fill would leak those bits into the register.

Finally, the bench writes to the frame pointer and to indices past the end, and reads through a disabled port. These expose a frame pointer that can be overwritten, and an error flag raised when no read was requested.

// File: rtl/callreg_file.sv
module callreg_file #(
  parameter int XLEN = 64,
  parameter int HALFW = 32,
  parameter int NREG = 11,
  parameter int NARG = 5,
  parameter logic [63:0] FP_VALUE = 64'h0000_0000_0000_F000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [XLEN-1:0] ctx_in,
  input  logic            rd_a_en,
  input  logic [3:0]      rd_a_idx,
  output logic [XLEN-1:0] rd_a_data,
  input  logic            rd_b_en,
  input  logic [3:0]      rd_b_idx,
  output logic [XLEN-1:0] rd_b_data,
  input  logic            wr_en,
  input  logic            wr_half,
  input  logic [3:0]      wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            call_done,
  input  logic [XLEN-1:0] call_ret,
  output logic            illegal_read,
  output logic            illegal_write
);
  localparam logic [3:0] FP_I = 4'(NREG - 1);
  localparam logic [3:0] ARG_I = 4'(NARG);
  localparam logic [3:0] CTX_I = 4'd1;
  localparam logic [NREG-1:0] VLD_RST = (NREG'(1) << 1) | (NREG'(1) << (NREG - 1));

  logic [XLEN-1:0] regs [NREG];
  logic [NREG-1:0] vld;

  logic a_ok, b_ok, wr_take;
  logic [XLEN-1:0] wr_val;

  assign a_ok = (rd_a_idx <= FP_I) && vld[rd_a_idx];
  assign b_ok = (rd_b_idx <= FP_I) && vld[rd_b_idx];
  assign rd_a_data = (rd_a_en && a_ok) ? regs[rd_a_idx] : '0;
  assign rd_b_data = (rd_b_en && b_ok) ? regs[rd_b_idx] : '0;
  assign illegal_read = (rd_a_en && !a_ok) || (rd_b_en && !b_ok);
  assign illegal_write = wr_en && (wr_idx >= FP_I);

  assign wr_val = wr_half ? {{(XLEN-HALFW){1'b0}}, wr_data[HALFW-1:0]} : wr_data;
  assign wr_take = wr_en && (wr_idx < FP_I)
                 && !(call_done && (wr_idx <= ARG_I))
                 && !(start && (wr_idx == CTX_I));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      regs[NREG-1] <= FP_VALUE[XLEN-1:0];
      vld <= VLD_RST;
    end else begin
      if (wr_take) begin
        regs[wr_idx] <= wr_val;
        vld[wr_idx] <= 1'b1;
      end
      if (call_done) begin
        regs[0] <= call_ret;
        vld[0] <= 1'b1;
        for (int i = 1; i <= NARG; i++) vld[i] <= 1'b0;
      end
      if (start) begin
        regs[1] <= ctx_in;
        vld[1] <= 1'b1;
      end
    end
  end

  p_fp_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_en && rd_a_idx == FP_I) |-> (rd_a_data == FP_VALUE[XLEN-1:0] && !illegal_read));

  p_bad_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_en && rd_b_idx > FP_I) |-> (illegal_read && rd_b_data == '0));

  p_half_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_half && wr_idx > ARG_I && wr_idx < FP_I)
    |=> (regs[$past(wr_idx)][XLEN-1:HALFW] == '0));

  p_call_ret_r6: assert property (@(posedge clk) disable iff (!rst_n)
    call_done |=> (regs[0] == $past(call_ret) && vld[0]));

  p_call_kill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (call_done && !start) |=> (vld[NARG:1] == '0));

  p_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (call_done && !wr_en) |=> ({regs[6], regs[7], regs[8], regs[9]}
                              == $past({regs[6], regs[7], regs[8], regs[9]})));

  p_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (regs[1] == $past(ctx_in) && vld[1]));
endmodule

// File: tb/callreg_file_bench.sv
module callreg_file_bench;
  localparam int CLK_P = 10;
  localparam logic [63:0] FPV = 64'h0000_0000_0000_F000;

  logic clk = 0, rst_n = 0;
  logic start = 0, rd_a_en = 0, rd_b_en = 0, wr_en = 0, wr_half = 0, call_done = 0;
  logic [3:0] rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
  logic [63:0] ctx_in = 0, wr_data = 0, call_ret = 0;
  logic [63:0] rd_a_data, rd_b_data;
  logic illegal_read, illegal_write;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  callreg_file #(.FP_VALUE(FPV)) u_callreg_file (
    .clk(clk), .rst_n(rst_n), .start(start), .ctx_in(ctx_in),
    .rd_a_en(rd_a_en), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_en(rd_b_en), .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_half(wr_half), .wr_idx(wr_idx), .wr_data(wr_data),
    .call_done(call_done), .call_ret(call_ret),
    .illegal_read(illegal_read), .illegal_write(illegal_write));

  // {half, idx, data, expected}
  localparam logic [132:0] VEC [6] = '{
    {1'b0, 4'd2, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF},
    {1'b1, 4'd3, 64'hFFFF_FFFF_8765_4321, 64'h0000_0000_8765_4321},
    {1'b0, 4'd9, 64'hDEAD_BEEF_0000_0001, 64'hDEAD_BEEF_0000_0001},
    {1'b1, 4'd0, 64'h1234_5678_FFFF_FFFF, 64'h0000_0000_FFFF_FFFF},
    {1'b0, 4'd6, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000},
    {1'b1, 4'd7, 64'hAAAA_AAAA_5555_5555, 64'h0000_0000_5555_5555}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic rd_a(input logic [3:0] i);
    rd_a_en = 1; rd_a_idx = i; #1;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 3);
    rst_n = 1;
    tick;
    // R1 reset state
    rd_a(4'd1); chk("R1 reg1", rd_a_data, 0); chk("R1 reg1 err", {63'd0, illegal_read}, 0);
    rd_a(4'd10); chk("R1 fp", rd_a_data, FPV);
    rd_b_en = 1; rd_b_idx = 4'd0; #1;
    chk("R1 reg0 invalid err", {63'd0, illegal_read}, 1); chk("R1 reg0 data", rd_b_data, 0);
    rd_b_en = 0; rd_a(4'd4); chk("R1 reg4 invalid", {63'd0, illegal_read}, 1);
    rd_a_en = 0;

    // R2/R3 vector table
    for (int k = 0; k < 6; k++) begin
      wr_en = 1; wr_half = VEC[k][132]; wr_idx = VEC[k][131:128]; wr_data = VEC[k][127:64];
      #1; chk("R2 no illegal_write", {63'd0, illegal_write}, 0);
      tick;
      wr_en = 0;
      rd_a_en = 1; rd_a_idx = VEC[k][131:128]; rd_b_en = 1; rd_b_idx = VEC[k][131:128]; #1;
      chk(VEC[k][132] ? "R3 half write A" : "R2 full write A", rd_a_data, VEC[k][63:0]);
      chk(VEC[k][132] ? "R3 half write B" : "R2 full write B", rd_b_data, VEC[k][63:0]);
      chk("R2 no illegal_read", {63'd0, illegal_read}, 0);
      rd_a_en = 0; rd_b_en = 0;
    end

    // R2 same-cycle read sees old value
    wr_en = 1; wr_half = 0; wr_idx = 4'd2; wr_data = 64'h55;
    rd_a(4'd2); chk("R2 old value in write cycle", rd_a_data, 64'h0123_4567_89AB_CDEF);
    tick; wr_en = 0; #1;
    chk("R2 new value next cycle", rd_a_data, 64'h55);

    // R5 invalid reads
    rd_a(4'd5); chk("R5 invalid data", rd_a_data, 0); chk("R5 invalid err", {63'd0, illegal_read}, 1);
    rd_a(4'd13); chk("R5 index past end err", {63'd0, illegal_read}, 1); chk("R5 past end data", rd_a_data, 0);
    rd_a_en = 0; rd_b_en = 0; rd_b_idx = 4'd8; #1;
    chk("R5 disabled no err", {63'd0, illegal_read}, 0); chk("R5 disabled data", rd_b_data, 0);

    // R4 writes to frame pointer / beyond
    wr_en = 1; wr_idx = 4'd10; wr_data = 64'h1; #1;
    chk("R4 fp write flagged", {63'd0, illegal_write}, 1);
    tick; wr_idx = 4'd12; #1;
    chk("R4 past-end write flagged", {63'd0, illegal_write}, 1);
    tick; wr_en = 0;
    rd_a(4'd10); chk("R4 fp unchanged", rd_a_data, FPV); rd_a_en = 0;

    // R6/R8 call with write to reg0
    call_done = 1; call_ret = 64'hCAFE_0000_0000_BEEF;
    wr_en = 1; wr_idx = 4'd0; wr_data = 64'h1111;
    tick; call_done = 0; wr_en = 0;
    rd_a(4'd0); chk("R8 call beats write reg0", rd_a_data, 64'hCAFE_0000_0000_BEEF);
    chk("R6 reg0 valid", {63'd0, illegal_read}, 0);
    for (int i = 1; i <= 5; i++) begin
      rd_a(4'(i)); chk("R6 arg reg invalid", {63'd0, illegal_read}, 1);
      chk("R6 arg reg reads zero", rd_a_data, 0);
    end
    rd_a(4'd6); chk("R7 reg6 kept", rd_a_data, 64'h8000_0000_0000_0000);
    rd_a(4'd7); chk("R7 reg7 kept", rd_a_data, 64'h0000_0000_5555_5555);
    rd_a(4'd9); chk("R7 reg9 kept", rd_a_data, 64'hDEAD_BEEF_0000_0001);
    rd_a_en = 0;

    // R8 write to arg reg dropped; callee-saved write lands
    call_done = 1; call_ret = 64'h2; wr_en = 1; wr_idx = 4'd4; wr_data = 64'h44;
    tick; wr_idx = 4'd8; wr_data = 64'h88;
    tick; call_done = 0; wr_en = 0;
    rd_a(4'd4); chk("R8 arg write dropped", {63'd0, illegal_read}, 1);
    rd_a(4'd8); chk("R8 reg8 write kept", rd_a_data, 64'h88);
    rd_a_en = 0;

    // R9 start overrides write and call invalidation
    start = 1; ctx_in = 64'h0000_7FFF_00C0_FFEE; call_done = 1;
    wr_en = 1; wr_idx = 4'd1; wr_data = 64'h77;
    tick; start = 0; call_done = 0; wr_en = 0;
    rd_a(4'd1); chk("R9 ctx loaded", rd_a_data, 64'h0000_7FFF_00C0_FFEE);
    chk("R9 reg1 valid", {63'd0, illegal_read}, 0);
    rd_a_en = 0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule